// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds a set of independent down-counting channels behind a small synchronous register bus. Each channel keeps a control word, a reload value and a running count that counts down toward zero. The channel decrements on every clock or only in cycles where a slow reference tick-enable is high. When the count reaches zero it raises a sticky status flag. That flag can drive a per-channel interrupt line. A channel can also reload itself and keep counting.

Software uses a channel in two ways. Setting the reload value to all ones with auto-reload gives a free-running time base; elapsed ticks are the bitwise inverse of the running count. Writing the reload value while the immediate-load control bit is set starts a one-shot countdown. Every register can be written directly, or through a set alias that ORs in the data, or through a clear alias that removes the bits that are 1 in the data. A global word can hold all channels in soft reset or freeze their counting. A read-only word reports the major version.

Top module: `cdtimer_top`

## Requirements
- R1: After reset every channel register and the global word read 0 and every interrupt line is low.
- R2: Channel n has control at 0x20+n*0x40, running count at 0x30+n*0x40 and reload value at 0x40+n*0x40. The global word is at 0x00 and the version word is at 0x20+NUM_CH*0x40. Reads of any other word, or of an address whose low two bits are not zero, return 0.
- R3: For each register, offset +0x4 is a set alias that ORs the data in, and offset +0x8 is a clear alias that clears the bits that are 1 in the data. A read at either alias returns the base register.
- R4: The clock select is control bits 3:0. Value 0xF counts one per clock. Value 0xB counts only in cycles where slow_tick_i is 1. Any other value, 0 included, holds the count.
- R5: Each counting cycle lowers a nonzero count by one. The cycle that takes the count from 1 to 0 sets the status flag, control bit 15.
- R6: With control bit 6 (auto-reload) clear, a count of zero stays at zero.
- R7: With auto-reload set, a counting cycle at zero loads the reload value, so the period is reload+1 ticks. With the reload value at all ones, the inverse of the count gives the elapsed ticks.
- R8: With control bit 7 (immediate load) set, a write to the reload value also puts the written value into the running count, and this overrides counting in that cycle. With bit 7 clear, the running count is not touched.
- R9: The status flag is cleared only by writing 1 to bit 15 through the control clear alias. Direct and set-alias writes leave it unchanged. An expiry in the same cycle as a clear leaves it set.
- R10: irq_o[n] is high exactly when channel n's status flag and its interrupt enable, control bit 14, are both 1.
- R11: Writes to the running-count address and to the version word are ignored.
- R12: While global bit 31 is 1, all channel registers are held at 0 and writes to them are ignored.
- R13: While global bit 30 is 1, no channel counts.
- R14: The version word carries VER_MAJOR (default 2) in bits 31:24 and 0 in its other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, taken at the rising edge |
| bus_addr_i | input | ADDR_W | Byte address for both reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, a combinational function of bus_addr_i |
| slow_tick_i | input | 1 | Slow reference tick enable |
| irq_o | output | NUM_CH | Per-channel interrupt lines |

## Verification
The hardest case to reach is an expiry and a status clear falling in the same clock edge. The count must be 1 at exactly the cycle in which the clear-alias write lands. To set this up, the bench loads a count of 2 with immediate load enabled. It turns on per-clock counting, waits one cycle, and issues the clear write so that its edge is the edge that takes the count to zero. The bench uses the same exact-cycle method for the slow-tick pulses and for the global freeze, each of which is checked against a count worked out from the number of edges that have passed.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 4;
  localparam int BIT_RELOAD = 6;
  localparam int BIT_UPDATE = 7;
  localparam int BIT_IRQEN  = 14;
  localparam int BIT_IRQ    = 15;
  localparam int BIT_SRST   = 31;
  localparam int BIT_GATE   = 30;
  localparam int VER_LSB    = 24;
  localparam int STRIDE     = 'h40;
  localparam int CTL_BASE   = 'h20;
  localparam int RUN_BASE   = 'h30;
  localparam int FIX_BASE   = 'h40;

  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'hF;
  localparam logic [SEL_W-1:0] SEL_SLOW   = 4'hB;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLEAR} wop_e;

  typedef struct packed {
    logic             irq;
    logic             irq_en;
    logic             update;
    logic             reload;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // Result of a bus operation on a stored word.
  function automatic logic [DATA_W-1:0] apply_op(wop_e op, logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return cur | wd;
      OP_CLEAR: return cur & ~wd;
      default:  return cur;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ctl_word(ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_W-1:0] = c.sel;
    w[BIT_RELOAD] = c.reload;
    w[BIT_UPDATE] = c.update;
    w[BIT_IRQEN]  = c.irq_en;
    w[BIT_IRQ]    = c.irq;
    return w;
  endfunction

  function automatic ctl_t ctl_fields(logic [DATA_W-1:0] w);
    ctl_t c;
    c.sel    = w[SEL_W-1:0];
    c.reload = w[BIT_RELOAD];
    c.update = w[BIT_UPDATE];
    c.irq_en = w[BIT_IRQEN];
    c.irq    = w[BIT_IRQ];
    return c;
  endfunction
endpackage

// File: rtl/cdtimer_regdec.sv
module cdtimer_regdec
  import cdtimer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wop_e              op_o,
  output logic              glb_hit_o,
  output logic              ver_hit_o,
  output logic [NUM_CH-1:0] ctl_hit_o,
  output logic [NUM_CH-1:0] run_hit_o,
  output logic [NUM_CH-1:0] fix_hit_o
);
  localparam int VER_OFF = CTL_BASE + NUM_CH * STRIDE;

  logic [ADDR_W-1:0] base_w;
  logic              aligned_w;

  // The alias selector sits in address bits 3:2; the base word ignores them.
  assign base_w    = {addr_i[ADDR_W-1:4], 4'h0};
  assign aligned_w = (addr_i[1:0] == 2'b00);

  always_comb begin
    op_o = OP_NONE;
    if (wr_i && aligned_w) begin
      case (addr_i[3:2])
        2'd0:    op_o = OP_WRITE;
        2'd1:    op_o = OP_SET;
        2'd2:    op_o = OP_CLEAR;
        default: op_o = OP_NONE;
      endcase
    end
  end

  assign glb_hit_o = aligned_w && (base_w == '0);
  assign ver_hit_o = aligned_w && (base_w == ADDR_W'(VER_OFF));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign ctl_hit_o[g] = aligned_w && (base_w == ADDR_W'(CTL_BASE + g * STRIDE));
    assign run_hit_o[g] = aligned_w && (base_w == ADDR_W'(RUN_BASE + g * STRIDE));
    assign fix_hit_o[g] = aligned_w && (base_w == ADDR_W'(FIX_BASE + g * STRIDE));
  end
endmodule

// File: rtl/cdtimer_chan.sv
module cdtimer_chan
  import cdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_en_i,
  input  logic              slow_tick_i,
  input  wop_e              ctl_op_i,
  input  wop_e              fix_op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [CNT_W-1:0]  run_o,
  output logic [CNT_W-1:0]  fix_o,
  output logic              irq_o,
  output logic              tick_o,
  output logic              expire_o,
  output logic              load_o,
  output logic              irq_clr_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] fix_q;

  ctl_t              ctl_wr_w;
  logic [DATA_W-1:0] fix_wide_w;
  logic [CNT_W-1:0]  fix_nxt_w;
  logic              fix_wr_w;

  // Count after one cycle that is not an immediate load.
  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] cur, logic [CNT_W-1:0] rld,
                                                  logic tick, logic reload);
    if (!tick)          return cur;
    if (cur != '0)      return cur - 1'b1;
    if (reload)         return rld;
    return '0;
  endfunction

  function automatic logic select_ticks(logic [SEL_W-1:0] sel, logic slow);
    return (sel == SEL_ALWAYS) || ((sel == SEL_SLOW) && slow);
  endfunction

  assign ctl_wr_w   = ctl_fields(apply_op(ctl_op_i, ctl_word(ctl_q), wdata_i));
  assign fix_wide_w = apply_op(fix_op_i, DATA_W'(fix_q), wdata_i);
  assign fix_nxt_w  = fix_wide_w[CNT_W-1:0];
  assign fix_wr_w   = (fix_op_i != OP_NONE);

  assign tick_o    = run_en_i && select_ticks(ctl_q.sel, slow_tick_i);
  assign load_o    = fix_wr_w && ctl_q.update;
  assign expire_o  = tick_o && !load_o && (run_q == CNT_W'(1));
  assign irq_clr_o = (ctl_op_i == OP_CLEAR) && wdata_i[BIT_IRQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      run_q <= '0;
      fix_q <= '0;
    end else if (clear_i) begin
      ctl_q <= '0;
      run_q <= '0;
      fix_q <= '0;
    end else begin
      ctl_q.sel    <= ctl_wr_w.sel;
      ctl_q.reload <= ctl_wr_w.reload;
      ctl_q.update <= ctl_wr_w.update;
      ctl_q.irq_en <= ctl_wr_w.irq_en;
      ctl_q.irq    <= expire_o || (ctl_q.irq && !irq_clr_o);
      fix_q        <= fix_nxt_w;
      run_q        <= load_o ? fix_nxt_w : step_count(run_q, fix_q, tick_o, ctl_q.reload);
    end
  end

  assign ctl_o = ctl_word(ctl_q);
  assign run_o = run_q;
  assign fix_o = fix_q;
  assign irq_o = ctl_q.irq && ctl_q.irq_en;
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdtimer_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 12,
  parameter int VER_MAJOR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              slow_tick_i,
  output logic [NUM_CH-1:0] irq_o
);
  wop_e              op_w;
  logic              glb_hit_w;
  logic              ver_hit_w;
  logic [NUM_CH-1:0] ctl_hit_w;
  logic [NUM_CH-1:0] run_hit_w;
  logic [NUM_CH-1:0] fix_hit_w;

  logic [1:0]        glb_q;
  logic [DATA_W-1:0] glb_word_w;
  logic [DATA_W-1:0] glb_nxt_w;
  logic              srst_w;
  logic              run_en_w;

  logic [NUM_CH-1:0]              tick_w;
  logic [NUM_CH-1:0]              expire_w;
  logic [NUM_CH-1:0]              load_w;
  logic [NUM_CH-1:0]              clr_w;
  logic [NUM_CH-1:0]              stat_w;
  logic [NUM_CH-1:0]              reload_w;
  logic [NUM_CH-1:0][DATA_W-1:0]  ctl_w;
  logic [NUM_CH-1:0][CNT_W-1:0]   run_w;
  logic [NUM_CH-1:0][CNT_W-1:0]   fix_w;

  cdtimer_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .op_o      (op_w),
    .glb_hit_o (glb_hit_w),
    .ver_hit_o (ver_hit_w),
    .ctl_hit_o (ctl_hit_w),
    .run_hit_o (run_hit_w),
    .fix_hit_o (fix_hit_w)
  );

  always_comb begin
    glb_word_w = '0;
    glb_word_w[BIT_SRST] = glb_q[1];
    glb_word_w[BIT_GATE] = glb_q[0];
  end

  assign glb_nxt_w = apply_op(glb_hit_w ? op_w : OP_NONE, glb_word_w, bus_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glb_q <= '0;
    else         glb_q <= {glb_nxt_w[BIT_SRST], glb_nxt_w[BIT_GATE]};
  end

  assign srst_w   = glb_q[1];
  assign run_en_w = !glb_q[0] && !glb_q[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cdtimer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (srst_w),
      .run_en_i    (run_en_w),
      .slow_tick_i (slow_tick_i),
      .ctl_op_i    (ctl_hit_w[g] ? op_w : OP_NONE),
      .fix_op_i    (fix_hit_w[g] ? op_w : OP_NONE),
      .wdata_i     (bus_wdata_i),
      .ctl_o       (ctl_w[g]),
      .run_o       (run_w[g]),
      .fix_o       (fix_w[g]),
      .irq_o       (irq_o[g]),
      .tick_o      (tick_w[g]),
      .expire_o    (expire_w[g]),
      .load_o      (load_w[g]),
      .irq_clr_o   (clr_w[g])
    );
    assign stat_w[g]   = ctl_w[g][BIT_IRQ];
    assign reload_w[g] = ctl_w[g][BIT_RELOAD];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (glb_hit_w) bus_rdata_o = glb_word_w;
    if (ver_hit_w) bus_rdata_o = DATA_W'(VER_MAJOR) << VER_LSB;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctl_hit_w[i]) bus_rdata_o = ctl_w[i];
      if (run_hit_w[i]) bus_rdata_o = DATA_W'(run_w[i]);
      if (fix_hit_w[i]) bus_rdata_o = DATA_W'(fix_w[i]);
    end
  end
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          srst_i,
  input logic [NUM_CH-1:0]             tick_i,
  input logic [NUM_CH-1:0]             expire_i,
  input logic [NUM_CH-1:0]             load_i,
  input logic [NUM_CH-1:0]             clr_i,
  input logic [NUM_CH-1:0]             stat_i,
  input logic [NUM_CH-1:0]             reload_i,
  input logic [NUM_CH-1:0]             irq_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]  run_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_expire_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[g] && !srst_i |=> stat_i[g]);

    assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[g] && !load_i[g] && !srst_i && (run_i[g] != '0) |=> run_i[g] == $past(run_i[g]) - 1'b1);

    assert_hold_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[g] == '0) && !reload_i[g] && !load_i[g] |=> run_i[g] == '0);

    assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i[g] && !load_i[g] && !srst_i |=> $stable(run_i[g]));

    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_i[g] && !clr_i[g] && !srst_i |=> stat_i[g]);

    assert_irq_needs_stat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[g] |-> stat_i[g]);

    assert_soft_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (run_i[g] == '0) && !stat_i[g]);
  end
endmodule

bind cdtimer_top cdtimer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .srst_i   (srst_w),
  .tick_i   (tick_w),
  .expire_i (expire_w),
  .load_i   (load_w),
  .clr_i    (clr_w),
  .stat_i   (stat_w),
  .reload_i (reload_w),
  .irq_i    (irq_o),
  .run_i    (run_w)
);

// File: tb/cdtimer_tb.sv
module cdtimer_top_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 12;

  localparam logic [AW-1:0] A_GLB = 12'h000;
  localparam logic [AW-1:0] A_C0  = 12'h020;
  localparam logic [AW-1:0] A_R0  = 12'h030;
  localparam logic [AW-1:0] A_F0  = 12'h040;
  localparam logic [AW-1:0] A_C1  = 12'h060;
  localparam logic [AW-1:0] A_R1  = 12'h070;
  localparam logic [AW-1:0] A_F1  = 12'h080;
  localparam logic [AW-1:0] A_VER = 12'h0A0;
  localparam logic [AW-1:0] SETA  = 12'h004;
  localparam logic [AW-1:0] CLRA  = 12'h008;

  localparam logic [31:0] K_RLD = 32'h40;
  localparam logic [31:0] K_UPD = 32'h80;
  localparam logic [31:0] K_EN  = 32'h4000;
  localparam logic [31:0] K_IRQ = 32'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic slow = 1'b0;
  logic [NCH-1:0] irq;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       req;
  } item_t;

  item_t exp_q[$];
  event  rd_ev;

  always #4 clk = ~clk;

  cdtimer_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .slow_tick_i (slow),
    .irq_o       (irq)
  );

  // Monitor: pops an expected item whenever the driver exposes a result.
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? 32'(irq) : rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  // All tasks start and end just after a falling edge.
  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.is_irq = 1'b0; it.req = req;
    exp_q.push_back(it);
    addr = a;
    #1 ->rd_ev;
    #1;
  endtask

  task automatic expect_irq(input logic [31:0] e, input string req);
    item_t it;
    it.exp = e; it.is_irq = 1'b1; it.req = req;
    exp_q.push_back(it);
    #1 ->rd_ev;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map, R14 version
    expect_rd(A_C0, 32'h0, "R1 ctl0");
    expect_rd(A_R0, 32'h0, "R1 run0");
    expect_rd(A_F1, 32'h0, "R1 fix1");
    expect_rd(A_GLB, 32'h0, "R1 glb");
    expect_irq(32'h0, "R1 irq");
    expect_rd(A_VER, 32'h0200_0000, "R14 version");
    expect_rd(12'h090, 32'h0, "R2 unmapped");
    expect_rd(A_C0 + 12'h1, 32'h0, "R2 misaligned");

    // R8 immediate load, R11 running count read-only, R14 version write ignored
    wr_reg(A_C0, K_UPD);
    wr_reg(A_F0, 32'd10);
    expect_rd(A_R0, 32'd10, "R8 load run0");
    expect_rd(A_F0, 32'd10, "R8 fix0");
    wr_reg(A_R0, 32'h55);
    expect_rd(A_R0, 32'd10, "R11 run write ignored");
    wr_reg(A_VER, 32'hFFFF_FFFF);
    expect_rd(A_VER, 32'h0200_0000, "R11 version write ignored");

    // R3 set alias, R4 per-clock select, R5 countdown
    wr_reg(A_C0 + SETA, 32'hF | K_EN);
    expect_rd(A_C0 + CLRA, 32'h408F, "R3 alias read");
    expect_rd(A_R0, 32'd10, "R4 first tick next edge");
    idle(3);
    expect_rd(A_R0, 32'd7, "R5 three ticks");
    idle(7);
    expect_rd(A_R0, 32'd0, "R5 reached zero");
    expect_rd(A_C0, 32'hC08F, "R5 status set");
    expect_irq(32'h1, "R10 irq high");
    idle(3);
    expect_rd(A_R0, 32'd0, "R6 holds zero");

    // R9 status immune to base/set writes; R10 enable gating
    wr_reg(A_C0, 32'h008F);
    expect_rd(A_C0, 32'h808F, "R9 base write keeps status");
    expect_irq(32'h0, "R10 enable off");
    wr_reg(A_C0 + SETA, K_EN);
    expect_irq(32'h1, "R10 enable on");
    wr_reg(A_C0 + CLRA, K_IRQ);
    expect_rd(A_C0, 32'h408F, "R9 cleared by clear alias");
    expect_irq(32'h0, "R10 irq low after clear");

    // R7 auto-reload on channel 1
    wr_reg(A_C1, K_UPD);
    wr_reg(A_F1, 32'd3);
    wr_reg(A_C1 + SETA, K_RLD | 32'hF);
    idle(3);
    expect_rd(A_R1, 32'd0, "R7 zero before reload");
    idle(1);
    expect_rd(A_R1, 32'd3, "R7 reloaded");
    idle(2);
    expect_rd(A_R1, 32'd1, "R7 counting again");
    wr_reg(A_F1, 32'hFFFF_FFFF);
    idle(5);
    addr = A_R1; #1 snap = ~rdata;
    total++;
    if (snap !== 32'd5) begin
      bad++;
      $display("FAIL R7 elapsed actual=%0d expected=5", snap);
    end

    // R4 slow select and stop
    wr_reg(A_C0 + CLRA, 32'hF);
    wr_reg(A_F0, 32'd20);
    wr_reg(A_C0 + SETA, 32'hB);
    idle(4);
    expect_rd(A_R0, 32'd20, "R4 slow without tick holds");
    slow = 1'b1;
    idle(2);
    slow = 1'b0;
    expect_rd(A_R0, 32'd18, "R4 two slow ticks");
    wr_reg(A_C0 + CLRA, 32'hF);
    slow = 1'b1;
    idle(3);
    slow = 1'b0;
    expect_rd(A_R0, 32'd18, "R4 select 0 stops");

    // R13 global freeze
    wr_reg(A_GLB + SETA, 32'h4000_0000);
    addr = A_R1; #1 snap = rdata;
    idle(4);
    expect_rd(A_R1, snap, "R13 frozen");
    wr_reg(A_GLB + CLRA, 32'h4000_0000);
    idle(2);
    expect_rd(A_R1, snap - 32'd2, "R13 resumes");

    // R12 soft reset
    wr_reg(A_GLB + SETA, 32'h8000_0000);
    idle(1);
    expect_rd(A_C1, 32'h0, "R12 ctl1 cleared");
    expect_rd(A_R1, 32'h0, "R12 run1 cleared");
    expect_rd(A_F1, 32'h0, "R12 fix1 cleared");
    wr_reg(A_F0, 32'd7);
    expect_rd(A_F0, 32'h0, "R12 write ignored");
    wr_reg(A_GLB + CLRA, 32'h8000_0000);
    expect_rd(A_GLB, 32'h0, "R12 glb released");

    // R9 expiry wins over a same-cycle clear
    wr_reg(A_C0, K_UPD);
    wr_reg(A_F0, 32'd2);
    wr_reg(A_C0 + SETA, 32'hF);
    expect_rd(A_R0, 32'd2, "R9 setup count");
    idle(1);
    wr_reg(A_C0 + CLRA, K_IRQ);
    expect_rd(A_C0, 32'h808F, "R9 expiry beats clear");

    // R8 load disabled
    wr_reg(A_C0 + CLRA, K_UPD);
    wr_reg(A_F0, 32'd50);
    expect_rd(A_F0, 32'd50, "R8 fix written");
    expect_rd(A_R0, 32'd0, "R8 run untouched");

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule